// File: doc/BRIEF.md
# Core Run-State Controller

This unit sits beside the fetch stage of a small processor core and decides whether the core is executing, sleeping or halted for a debugger. Every cycle it looks at the current instruction word and recognises four system-control opcodes: no-operation, sleep, watchdog reset and break. Each of these is a single-word, single-cycle instruction that leaves every status flag untouched. The unit only interprets opcodes while the core is running. In the sleeping and halted states it holds a stall line high, so the program counter stays where it is.

A sleep instruction puts the core to sleep only if the sleep-enable control bit is set. Otherwise it does nothing. An interrupt request wakes the core, and because the program counter did not move during sleep, execution continues with the instruction that follows the sleep. A break instruction halts the core for a debugger, but only when no lock bit is set and both debug-enable fuses are programmed. In any other case it has no effect. Once halted, the core leaves that state only when the debugger asserts resume. A watchdog reset instruction produces a one-cycle clear pulse for an external watchdog timer.

Top module: `core_runstate_ctl`

## Requirements
- R1: While reset is active, and on the first cycle after it, `run_state` reads 0 (running), `stall` is low and `wdt_clear` is low.
- R2: In the running state, the sleep opcode 16'h9588 with `sleep_en` high makes `run_state` read 1 (sleeping) after the next clock edge.
- R3: In the running state, the sleep opcode with `sleep_en` low has no effect: `run_state` stays 0 and `stall` stays low.
- R4: In the sleeping state, a high `irq` makes `run_state` read 0 after the next clock edge. Without `irq`, the core stays asleep.
- R5: In the running state, the watchdog opcode 16'h95A8 makes `wdt_clear` high for exactly the one cycle after the clock edge that samples it. Back-to-back watchdog opcodes give one pulse cycle each.
- R6: In the running state, the break opcode 16'h9598 makes `run_state` read 2 (stopped) after the next clock edge. This requires every bit of `lock` to be 0 and both `dbg_fuse_a` and `dbg_fuse_b` to be 1 (programmed).
- R7: In the running state, the break opcode has no effect when any `lock` bit is 1 or when either fuse input is 0.
- R8: The stopped state is left only through `dbg_resume`. `irq` and instruction words leave it unchanged, and `dbg_resume` returns `run_state` to 0 after the next clock edge.
- R9: While sleeping or stopped, the instruction word is ignored: a watchdog opcode gives no pulse, and sleep or break opcodes do not change the state.
- R10: The no-operation word 16'h0000, and any word other than the three active opcodes, leaves `run_state` at 0 and `wdt_clear` low.
- R11: `stall` is high exactly when `run_state` is not 0. `run_state` never reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word being executed this cycle |
| sleep_en | input | 1 | Sleep-enable control bit |
| irq | input | 1 | Interrupt request, wakes a sleeping core |
| lock | input | LOCK_W (2) | Lock bits, any 1 disables break |
| dbg_fuse_a | input | 1 | First debug-enable fuse, 1 = programmed |
| dbg_fuse_b | input | 1 | Second debug-enable fuse, 1 = programmed |
| dbg_resume | input | 1 | Debugger resume request |
| run_state | output | 2 | 0 running, 1 sleeping, 2 stopped |
| wdt_clear | output | 1 | One-cycle watchdog clear pulse |
| stall | output | 1 | Holds the program counter |

## Verification
The bench sweeps every combination of the lock bits and the two fuses under a break opcode. It expects a halt only for the single fully enabled combination, which catches a design that ORs the fuses or tests only one lock bit. It checks that the stopped state ignores `irq`, and that the sleeping state ignores `dbg_resume` and every opcode. A design that leaked wake sources across the two states, or kept decoding while stalled, would change state or pulse `wdt_clear` in those checks. It also sends back-to-back watchdog opcodes and a sweep of unrelated words, which exposes a pulse that is stretched, merged or raised by a partial opcode match.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   typedef enum logic [1:0] {
      RS_RUN   = 2'd0,
      RS_SLEEP = 2'd1,
      RS_STOP  = 2'd2
   } run_state_e;

   localparam int unsigned OPC_W = 16;

   localparam logic [OPC_W-1:0] OPC_IDLE  = 16'h0000;
   localparam logic [OPC_W-1:0] OPC_NAP   = 16'h9588;
   localparam logic [OPC_W-1:0] OPC_BARK  = 16'h95A8;
   localparam logic [OPC_W-1:0] OPC_HALT  = 16'h9598;

   typedef struct packed {
      logic nap;
      logic bark;
      logic halt;
   } sysop_t;

endpackage

// File: rtl/sysop_decode.sv
module sysop_decode
   import rsc_pkg::*;
#(
   parameter int unsigned INSTR_W = 16
) (
   input  logic [INSTR_W-1:0] instr,
   output sysop_t             op
);

   generate
      if (INSTR_W != OPC_W) begin : g_bad_width
         $error("sysop_decode: INSTR_W must equal the opcode width");
      end
   endgenerate

   always_comb begin
      op      = '0;
      op.nap  = (instr == OPC_NAP);
      op.bark = (instr == OPC_BARK);
      op.halt = (instr == OPC_HALT);
   end

endmodule

// File: rtl/dbg_gate.sv
module dbg_gate #(
   parameter int unsigned LOCK_W = 2
) (
   input  logic [LOCK_W-1:0] lock,
   input  logic              fuse_a,
   input  logic              fuse_b,
   output logic              halt_ok
);

   generate
      if (LOCK_W < 1) begin : g_bad_lock
         $error("dbg_gate: LOCK_W must be at least 1");
      end
   endgenerate

   logic any_lock;

   always_comb begin
      any_lock = |lock;
      halt_ok  = !any_lock && fuse_a && fuse_b;
   end

endmodule

// File: rtl/run_fsm.sv
module run_fsm
   import rsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sysop_t     op,
   input  logic       sleep_en,
   input  logic       irq,
   input  logic       resume,
   input  logic       halt_ok,
   output run_state_e state,
   output logic       bark_hit
);

   run_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         RS_RUN: begin
            if (op.nap && sleep_en)      state_nx = RS_SLEEP;
            else if (op.halt && halt_ok) state_nx = RS_STOP;
         end
         RS_SLEEP: if (irq)    state_nx = RS_RUN;
         RS_STOP:  if (resume) state_nx = RS_RUN;
         default:              state_nx = RS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= RS_RUN;
      else        state <= state_nx;
   end

   assign bark_hit = (state == RS_RUN) && op.bark;

endmodule

// File: rtl/core_runstate_ctl.sv
module core_runstate_ctl
   import rsc_pkg::*;
#(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned LOCK_W  = 2,
   parameter bit          WDR_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic               sleep_en,
   input  logic               irq,
   input  logic [LOCK_W-1:0]  lock,
   input  logic               dbg_fuse_a,
   input  logic               dbg_fuse_b,
   input  logic               dbg_resume,
   output logic [1:0]         run_state,
   output logic               wdt_clear,
   output logic               stall
);

   sysop_t     op;
   logic       halt_ok;
   logic       bark_hit;
   run_state_e state;

   sysop_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr),
      .op    (op)
   );

   dbg_gate #(.LOCK_W(LOCK_W)) u_gate (
      .lock    (lock),
      .fuse_a  (dbg_fuse_a),
      .fuse_b  (dbg_fuse_b),
      .halt_ok (halt_ok)
   );

   run_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .sleep_en (sleep_en),
      .irq      (irq),
      .resume   (dbg_resume),
      .halt_ok  (halt_ok),
      .state    (state),
      .bark_hit (bark_hit)
   );

   generate
      if (WDR_REG) begin : g_wdr_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= bark_hit;
         end
         assign wdt_clear = pulse_q;
      end else begin : g_wdr_comb
         assign wdt_clear = bark_hit && rst_n;
      end
   endgenerate

   assign run_state = state;
   assign stall     = (state != RS_RUN);

endmodule

// File: rtl/runstate_chk.sv
module runstate_chk
   import rsc_pkg::*;
#(
   parameter int unsigned INSTR_W = 16,
   parameter int unsigned LOCK_W  = 2,
   parameter bit          WDR_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [INSTR_W-1:0] instr,
   input logic               sleep_en,
   input logic               irq,
   input logic [LOCK_W-1:0]  lock,
   input logic               dbg_fuse_a,
   input logic               dbg_fuse_b,
   input logic               dbg_resume,
   input logic [1:0]         run_state,
   input logic               wdt_clear,
   input logic               stall
);

   // R11
   legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state != 2'd3) && (stall == (run_state != 2'd0)));

   // R2
   nap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd0 && instr == OPC_NAP && sleep_en) |=> (run_state == 2'd1));

   // R3
   nap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd0 && instr == OPC_NAP && !sleep_en) |=> (run_state == 2'd0));

   // R4
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd1 && irq) |=> (run_state == 2'd0));

   // R4
   nap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd1 && !irq) |=> (run_state == 2'd1));

   // R6
   halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd0 && instr == OPC_HALT && !(|lock) && dbg_fuse_a && dbg_fuse_b)
      |=> (run_state == 2'd2));

   // R7
   halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd0 && instr == OPC_HALT && ((|lock) || !dbg_fuse_a || !dbg_fuse_b))
      |=> (run_state == 2'd0));

   // R8
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_state == 2'd2 && !dbg_resume) |=> (run_state == 2'd2));

   generate
      if (WDR_REG) begin : g_reg_chk
         // R5
         wdt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wdt_clear |-> $past(run_state == 2'd0 && instr == OPC_BARK));
         // R9
         wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_state != 2'd0) |=> !wdt_clear);
      end
   endgenerate

endmodule

bind core_runstate_ctl runstate_chk #(
   .INSTR_W (INSTR_W),
   .LOCK_W  (LOCK_W),
   .WDR_REG (WDR_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr      (instr),
   .sleep_en   (sleep_en),
   .irq        (irq),
   .lock       (lock),
   .dbg_fuse_a (dbg_fuse_a),
   .dbg_fuse_b (dbg_fuse_b),
   .dbg_resume (dbg_resume),
   .run_state  (run_state),
   .wdt_clear  (wdt_clear),
   .stall      (stall)
);

// File: tb/tb_core_runstate_ctl.sv
module tb_core_runstate_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int LW = 2;

   localparam logic [15:0] W_NOP = 16'h0000;
   localparam logic [15:0] W_SLP = 16'h9588;
   localparam logic [15:0] W_WDR = 16'h95A8;
   localparam logic [15:0] W_BRK = 16'h9598;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   instr = W_NOP;
   logic          sleep_en = 1'b0;
   logic          irq = 1'b0;
   logic [LW-1:0] lock = '0;
   logic          fa = 1'b1;
   logic          fb = 1'b1;
   logic          resume = 1'b0;
   logic [1:0]    run_state;
   logic          wdt_clear;
   logic          stall;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_runstate_ctl #(.INSTR_W(16), .LOCK_W(LW), .WDR_REG(1'b1)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr      (instr),
      .sleep_en   (sleep_en),
      .irq        (irq),
      .lock       (lock),
      .dbg_fuse_a (fa),
      .dbg_fuse_b (fb),
      .dbg_resume (resume),
      .run_state  (run_state),
      .wdt_clear  (wdt_clear),
      .stall      (stall)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic chk_all(input string req, input int st, input int wd);
      chk({req, " state"}, run_state, st);
      chk({req, " stall"}, stall, (st != 0) ? 1 : 0);
      chk({req, " wdt"}, wdt_clear, wd);
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic step(input logic [15:0] w, input logic sen, input logic ir, input logic rs);
      instr = w; sleep_en = sen; irq = ir; resume = rs;
      @(posedge clk);
      @(negedge clk);
      instr = W_NOP; irq = 1'b0; resume = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      @(negedge clk);
      // R1 during reset
      chk_all("R1 in-reset", 0, 0);
      rst_n = 1'b1;
      step(W_NOP, 1'b0, 1'b0, 1'b0);
      chk_all("R1 after-reset", 0, 0);

      // R10 sweep of unrelated words
      for (int i = 0; i < 64; i++) begin
         logic [15:0] w;
         w = 16'(i * 1031 + 16'h9500);
         if (w == W_SLP || w == W_WDR || w == W_BRK) w = W_NOP;
         step(w, 1'b1, 1'b0, 1'b0);
         chk_all("R10 other word", 0, 0);
      end

      // R5 single and back-to-back pulses
      step(W_WDR, 1'b0, 1'b0, 1'b0);
      chk_all("R5 pulse", 0, 1);
      step(W_NOP, 1'b0, 1'b0, 1'b0);
      chk_all("R5 pulse end", 0, 0);
      step(W_WDR, 1'b0, 1'b0, 1'b0);
      chk_all("R5 b2b first", 0, 1);
      step(W_WDR, 1'b0, 1'b0, 1'b0);
      chk_all("R5 b2b second", 0, 1);
      step(W_NOP, 1'b0, 1'b0, 1'b0);
      chk_all("R5 b2b end", 0, 0);

      // R3 sleep disabled, R2 sleep enabled
      step(W_SLP, 1'b0, 1'b0, 1'b0);
      chk_all("R3 nap disabled", 0, 0);
      step(W_SLP, 1'b1, 1'b0, 1'b0);
      chk_all("R2 nap entered", 1, 0);

      // R9 opcodes ignored while sleeping, R4 resume is not a wake source
      step(W_WDR, 1'b1, 1'b0, 1'b0);
      step(W_NOP, 1'b1, 1'b0, 1'b0);
      chk_all("R9 no pulse asleep", 1, 0);
      step(W_BRK, 1'b1, 1'b0, 1'b0);
      chk_all("R9 halt ignored asleep", 1, 0);
      step(W_NOP, 1'b1, 1'b0, 1'b1);
      chk_all("R4 resume no wake", 1, 0);
      step(W_NOP, 1'b1, 1'b1, 1'b0);
      chk_all("R4 irq wake", 0, 0);
      step(W_WDR, 1'b1, 1'b0, 1'b0);
      chk_all("R4 runs after wake", 0, 1);

      // R6 / R7 sweep of lock and fuse settings
      for (int k = 0; k < (1 << (LW + 2)); k++) begin
         logic ok;
         lock = LW'(k);
         fa   = k[LW];
         fb   = k[LW+1];
         ok   = (lock == '0) && fa && fb;
         step(W_BRK, 1'b0, 1'b0, 1'b0);
         if (ok) begin
            chk_all("R6 halt", 2, 0);
            step(W_NOP, 1'b0, 1'b1, 1'b0);
            chk_all("R8 irq ignored stopped", 2, 0);
            step(W_WDR, 1'b0, 1'b0, 1'b0);
            step(W_NOP, 1'b0, 1'b0, 1'b0);
            chk_all("R9 no pulse stopped", 2, 0);
            step(W_SLP, 1'b1, 1'b0, 1'b0);
            chk_all("R9 nap ignored stopped", 2, 0);
            step(W_NOP, 1'b0, 1'b0, 1'b1);
            chk_all("R8 resume", 0, 0);
         end else begin
            chk_all("R7 halt blocked", 0, 0);
         end
      end
      lock = '0; fa = 1'b1; fb = 1'b1;

      // R11 encodings across all three states
      step(W_SLP, 1'b1, 1'b0, 1'b0);
      chk("R11 sleep code", run_state, 1);
      step(W_NOP, 1'b1, 1'b1, 1'b0);
      step(W_BRK, 1'b0, 1'b0, 1'b0);
      chk("R11 stop code", run_state, 2);
      chk("R11 stall stop", stall, 1);
      step(W_NOP, 1'b0, 1'b0, 1'b1);
      chk("R11 run code", run_state, 0);

      // R1 reset from a non-running state
      step(W_SLP, 1'b1, 1'b0, 1'b0);
      rst_n = 1'b0;
      step(W_NOP, 1'b0, 1'b0, 1'b0);
      chk_all("R1 reset from sleep", 0, 0);
      rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule